// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus. It gives a bus host read and write access to a bank of 128 byte-wide registers. The bus clock and data inputs are first synchronised to the system clock. The block never drives the data line high. It either pulls the line low through `sda_oe` or lets it go, and the board's pull-up and the host's own open-drain output resolve the level.

A transfer starts with a start condition and a device-ID byte. Next comes a register address byte. That byte loads a 7-bit pointer and picks between two modes: alternating mode, where every data byte needs its own address byte in front of it, and auto-increment mode, where data bytes follow one another and the pointer steps through the bank. To read, the host first sets the pointer with a write transfer, then issues a repeated start with the read direction bit and clocks out bytes.

Top module: `i2c_regslave`

## Requirements
- R1: A byte after start whose bits [7:1] equal the parameter `DEV_ID` is acknowledged. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R2: A device-ID byte that does not match gets no acknowledge. The line stays released and nothing on the bus has any effect until the next start condition.
- R3: In a write transfer every byte is acknowledged. The slave pulls the line low from the falling clock edge after bit 8 until the falling edge of the 9th clock, so the line is low for the whole high time of that clock.
- R4: Bits [6:0] of a register address byte load the pointer, and bit 7 selects auto-increment. With bit 7 at 0 the transfer alternates: address byte, data byte, address byte, data byte. Each data byte goes only to the register named by the address byte just before it.
- R5: With auto-increment on, consecutive write data bytes go to pointer, pointer+1, and so on. The pointer wraps from 127 to 0.
- R6: In a read transfer the register at the pointer is shifted out MSB first. The slave's output changes only while the clock is low. After a host acknowledge, the next byte comes from pointer+1 when auto-increment is on, and from the same register when it is off.
- R7: If the host does not acknowledge a read byte, the slave releases the line and keeps it released until the next start.
- R8: A stop condition at any point returns the slave to idle with the line released. A start condition at any point, including a repeated start in the middle of a byte, begins a new device-ID phase.
- R9: After reset the line is released and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock from the host |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench targets the pointer and mode corners:
- An alternating write that lands in the register after the addressed one shows a pointer that increments when it should not.
- A burst that crosses 127 catches a pointer that does not wrap, or that carries into the mode bit.
- A wrong device ID followed by a valid-looking address and data pair shows whether the slave really ignores the bus until the next start.
- A host NACK followed by a dummy byte shows a slave that keeps shifting data out after the host gave up.
- Stops and repeated starts in the middle of a byte expose a bit counter that is not cleared: the next transfer's bytes come out shifted or are not acknowledged.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ID = 7'h3A,
  parameter int         NREG   = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {IDLE, DEVID, REGA, WDAT, RDAT, IGN} st_t;

  st_t st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] mem [NREG];
  logic [7:0] sr, tx;
  logic [3:0] cnt;
  logic ackph, rw, ainc, mack;
  logic [AW-1:0] ptr;

  wire scl_r = scl_q[1] & ~scl_q[2];
  wire scl_f = ~scl_q[1] & scl_q[2];
  wire scl_h = scl_q[1] & scl_q[2];
  wire sda_s = sda_q[1];
  wire start = scl_h & ~sda_q[1] & sda_q[2];
  wire stop  = scl_h & sda_q[1] & ~sda_q[2];
  wire [AW-1:0] nptr = ainc ? ptr + 1'b1 : ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      sr <= '0;
      tx <= '0;
      cnt <= '0;
      ackph <= 1'b0;
      rw <= 1'b0;
      ainc <= 1'b0;
      mack <= 1'b0;
      ptr <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (start) begin
      st <= DEVID;
      cnt <= '0;
      ackph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st <= IDLE;
      cnt <= '0;
      ackph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != IDLE && st != IGN) begin
      if (scl_r) begin
        if (!ackph) begin
          if (cnt < 4'd8) begin
            sr <= {sr[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end
        end else if (st == RDAT) begin
          mack <= ~sda_s;
        end
      end else if (scl_f) begin
        if (!ackph && cnt == 4'd8) begin
          ackph <= 1'b1;
          case (st)
            DEVID:
              if (sr[7:1] == DEV_ID) begin
                sda_oe <= 1'b1;
                rw <= sr[0];
              end else begin
                st <= IGN;
                ackph <= 1'b0;
                sda_oe <= 1'b0;
              end
            REGA: begin
              ptr <= sr[AW-1:0];
              ainc <= sr[7];
              sda_oe <= 1'b1;
            end
            WDAT: begin
              mem[ptr] <= sr;
              sda_oe <= 1'b1;
              if (ainc) ptr <= ptr + 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (ackph) begin
          ackph <= 1'b0;
          cnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            DEVID:
              if (rw) begin
                st <= RDAT;
                tx <= mem[ptr];
                sda_oe <= ~mem[ptr][7];
              end else begin
                st <= REGA;
              end
            REGA: st <= WDAT;
            WDAT: st <= ainc ? WDAT : REGA;
            default:
              if (mack) begin
                ptr <= nptr;
                tx <= mem[nptr];
                sda_oe <= ~mem[nptr][7];
              end else begin
                st <= IGN;
              end
          endcase
        end else if (st == RDAT) begin
          sda_oe <= ~tx[3'd7 - cnt[2:0]];
        end
      end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic       ackph
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_RDAT = 3'd4;
  localparam logic [2:0] S_IGN  = 3'd5;

  p_oe_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ackph && st != S_RDAT && scl_i) |-> sda_oe);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  p_ign_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);

  p_host_ack_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ackph && st == S_RDAT) |-> !sda_oe);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(st), .ackph(ackph)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
  localparam logic [6:0] ID = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_regslave #(.DEV_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); a1 = sda_line; q(); a2 = sda_line;
    scl_m = 1'b0; q();
    ack = !a1 && !a2;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1'b1; q(); b = {b[6:0], sda_line}; q(); scl_m = 1'b0;
    end
    q();
    send_bit(!give_ack);
  endtask

  task automatic set_ptr(input logic [6:0] a, input bit inc);
    bit ack;
    bus_start();
    wbyte({ID, 1'b0}, ack);
    wbyte({inc, a}, ack);
  endtask

  task automatic read_one(input logic [6:0] a, output logic [7:0] b);
    bit ack;
    set_ptr(a, 1'b0);
    bus_start();
    wbyte({ID, 1'b1}, ack);
    rbyte(1'b0, b);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk(sda_oe == 1'b0, "R9 line released after reset", sda_oe, 0);
    read_one(7'h0A, b);
    chk(b == 8'h00, "R9 register zero after reset", b, 0);
  endtask

  task automatic t_alternate();
    bit ack;
    logic [7:0] b;
    bus_start();
    wbyte({ID, 1'b0}, ack); chk(ack, "R1 device ID acknowledged", ack, 1);
    wbyte(8'h05, ack);      chk(ack, "R3 address byte acknowledged", ack, 1);
    wbyte(8'hA5, ack);      chk(ack, "R3 data byte acknowledged", ack, 1);
    wbyte(8'h21, ack);      chk(ack, "R4 second address byte acknowledged", ack, 1);
    wbyte(8'h3C, ack);      chk(ack, "R3 second data byte acknowledged", ack, 1);
    bus_stop();
    read_one(7'h05, b); chk(b == 8'hA5, "R4 first alternating write", b, 8'hA5);
    read_one(7'h21, b); chk(b == 8'h3C, "R4 second alternating write", b, 8'h3C);
    read_one(7'h06, b); chk(b == 8'h00, "R4 neighbour untouched", b, 0);
  endtask

  task automatic t_autoinc();
    bit ack;
    logic [7:0] b;
    bus_start();
    wbyte({ID, 1'b0}, ack);
    wbyte(8'hFE, ack);
    wbyte(8'h11, ack);
    wbyte(8'h22, ack);
    wbyte(8'h33, ack); chk(ack, "R5 burst byte acknowledged", ack, 1);
    bus_stop();
    read_one(7'h7E, b); chk(b == 8'h11, "R5 burst byte 0", b, 8'h11);
    read_one(7'h7F, b); chk(b == 8'h22, "R5 burst byte 1", b, 8'h22);
    read_one(7'h00, b); chk(b == 8'h33, "R5 wrap to 0", b, 8'h33);
  endtask

  task automatic t_read_burst();
    bit ack;
    logic [7:0] b;
    set_ptr(7'h7E, 1'b1);
    bus_start();
    wbyte({ID, 1'b1}, ack); chk(ack, "R1 read ID acknowledged", ack, 1);
    rbyte(1'b1, b); chk(b == 8'h11, "R6 autoinc read 0", b, 8'h11);
    rbyte(1'b1, b); chk(b == 8'h22, "R6 autoinc read 1", b, 8'h22);
    rbyte(1'b0, b); chk(b == 8'h33, "R6 autoinc read wrap", b, 8'h33);
    bus_stop();
    set_ptr(7'h05, 1'b0);
    bus_start();
    wbyte({ID, 1'b1}, ack);
    rbyte(1'b1, b); chk(b == 8'hA5, "R6 fixed read 0", b, 8'hA5);
    rbyte(1'b0, b); chk(b == 8'hA5, "R6 fixed read repeats", b, 8'hA5);
    bus_stop();
  endtask

  task automatic t_bad_id();
    bit ack;
    logic [7:0] b;
    bus_start();
    wbyte({ID ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 wrong ID not acknowledged", ack, 0);
    wbyte(8'h05, ack); chk(!ack, "R2 later byte ignored", ack, 0);
    wbyte(8'h77, ack);
    bus_stop();
    read_one(7'h05, b); chk(b == 8'hA5, "R2 register unchanged", b, 8'hA5);
  endtask

  task automatic t_nack();
    bit ack;
    logic [7:0] b;
    set_ptr(7'h21, 1'b0);
    bus_start();
    wbyte({ID, 1'b1}, ack);
    rbyte(1'b0, b); chk(b == 8'h3C, "R7 byte before host NACK", b, 8'h3C);
    rbyte(1'b0, b); chk(b == 8'hFF, "R7 line released after NACK", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_abort();
    bit ack;
    logic [7:0] b;
    bus_start();
    wbyte({ID, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
    bus_start();
    wbyte({ID, 1'b0}, ack); chk(ack, "R8 new transfer after stop", ack, 1);
    wbyte(8'h40, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    wbyte({ID, 1'b0}, ack); chk(ack, "R8 repeated start mid byte", ack, 1);
    wbyte(8'h40, ack);
    wbyte(8'h5A, ack);
    bus_stop();
    read_one(7'h40, b); chk(b == 8'h5A, "R8 write after aborted byte", b, 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_alternate();
    t_autoinc();
    t_read_burst();
    t_bad_id();
    t_nack();
    t_abort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule